// File: doc/BRIEF.md
# Reference PLL Bring-Up Sequencer

This block is a small bus master that brings a shared reference PLL into service once, after a start pulse. It accepts a three-bit code naming the frequency of the PLL's reference input. An unsupported code ends the run at once with an error and no bus traffic. A supported code sets the PLL's reference registers over a simple 32-bit register bus. Every register update is a read-modify-write that changes only its own field. The block then enables lock detection and drops the PLL's analog soft reset for a fixed time. After the reset returns high, it reads the lock status at a fixed interval until lock is reported or a poll budget runs out.

All waiting is counted in clock cycles. The parameters give the clock rate in cycles per microsecond and the reset, poll and timeout times in microseconds, so a bench can shrink them. The bus slave returns read data one cycle after the read strobe. Three flags report the outcome: done, error and lock timeout. All three hold until the next accepted start.

Top module: `pll_bringup_seq`

## Requirements
- R1: After synchronous reset the bus strobes and the done, error and timeout flags are all low.
- R2: For codes 0 (25 MHz), 1 (31.25 MHz), 2 (40 MHz), 3 (48 MHz) and 4 (50 MHz), the first access reads register 0x784. The write that follows places index 3, 4, 6, 7 or 8 into bits [3:0] and keeps bits [31:4] as read.
- R3: For code 5 (96 MHz), the write to 0x784 carries index 7 in bits [3:0] and the value 2 in bits [8:4], with all other bits as read. A read-modify-write of register 0x028 then clears bits [9:8] and keeps the rest.
- R4: Codes 6 and 7 are unsupported. The edge that accepts the start sets done and error, and no bus access follows.
- R5: A read-modify-write of register 0x78C then sets bit 15 and keeps all other bits.
- R6: Register 0x780 then has bit 6 cleared and later set, each by its own read-modify-write, with other bits kept. The write strobe that sets the bit comes exactly RST_US*CYC_PER_US cycles after the write strobe that clears it.
- R7: After that, register 0x064 is read with the read strobes exactly POLL_US*CYC_PER_US cycles apart. The first read with bit 8 set ends the run with done high and error and timeout low.
- R8: If TIMEOUT_US/POLL_US lock reads in a row all show bit 8 clear, the run ends with done, error and timeout all high, and no further access follows.
- R9: Each read-modify-write is a read strobe, two idle cycles and then a write strobe. At least one idle cycle separates any two accesses. Read and write strobes never coincide, and every address is word aligned and no higher than 0x7FC.
- R10: A start pulse during a run is ignored, and the run completes with the code taken at its own start. The flags hold until the next accepted start, and that start clears them on the same edge.
- R11: Accesses occur in a fixed order: 0x784, then 0x028 (code 5 only), then 0x78C, then the 0x780 clear, then the 0x780 set, then the lock reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle start request, taken only when idle |
| ref_code_i | input | 3 | Reference frequency code, sampled with the start |
| bus_addr_o | output | 12 | Byte address of the current access |
| bus_wdata_o | output | 32 | Write data |
| bus_we_o | output | 1 | Write strobe, one cycle per write |
| bus_re_o | output | 1 | Read strobe, one cycle per read |
| bus_rdata_i | input | 32 | Read data, valid the cycle after the read strobe |
| done_o | output | 1 | Run finished (any outcome) |
| err_o | output | 1 | Unsupported code or lock timeout |
| tmo_o | output | 1 | Lock not seen within the poll budget |

## Verification
The first read strobe appears in the cycle after the edge that accepts the start. Each write strobe follows its read strobe by three cycles, and the flags change on the accepting edge, or on the edge after the last lock read's data arrives. A driver task computes the expected accesses from the slave model's register contents and queues them. A monitor samples the strobes on the falling clock edge and checks each access against the queue as it appears. The monitor records the cycle numbers of the two writes to 0x780 and of successive lock reads, and compares the gaps against the reset and poll intervals. The flags are sampled one falling edge after the accepting edge and again after the run's final access.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_SRCSEL = 12'h028;
    localparam logic [ADDR_W-1:0] A_LOCK   = 12'h064;
    localparam logic [ADDR_W-1:0] A_ANARST = 12'h780;
    localparam logic [ADDR_W-1:0] A_REFCFG = 12'h784;
    localparam logic [ADDR_W-1:0] A_CTRL   = 12'h78C;
    localparam logic [ADDR_W-1:0] A_MAX    = 12'h7FC;

    localparam int LOCK_BIT = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD,
        S_CAP,
        S_MRG,
        S_WR,
        S_NXT,
        S_HOLD,
        S_PRD,
        S_PCAP,
        S_PWAIT
    } seq_state_t;

    typedef enum logic [2:0] {
        K_REF,
        K_SRC,
        K_LDE,
        K_RLO,
        K_RHI
    } seq_step_t;

endpackage

// File: rtl/pbs_refmap.sv
module pbs_refmap (
    input  logic [2:0] code_i,
    output logic       ok_o,
    output logic [3:0] idx_o,
    output logic       div2_o
);
    always_comb begin
        ok_o   = 1'b1;
        div2_o = 1'b0;
        idx_o  = 4'd0;
        case (code_i)
            3'd0: idx_o = 4'd3;
            3'd1: idx_o = 4'd4;
            3'd2: idx_o = 4'd6;
            3'd3: idx_o = 4'd7;
            3'd4: idx_o = 4'd8;
            3'd5: begin
                idx_o  = 4'd7;
                div2_o = 1'b1;
            end
            default: ok_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pbs_timer.sv
module pbs_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         exp_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign exp_o = (cnt_q == '0);
endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
    import pbs_pkg::*;
#(
    parameter int CYC_PER_US = 100,
    parameter int RST_US     = 1100,
    parameter int POLL_US    = 100,
    parameter int TIMEOUT_US = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [2:0]        ref_code_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic              bus_we_o,
    output logic              bus_re_o,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic              done_o,
    output logic              err_o,
    output logic              tmo_o
);
    localparam int RST_CYC   = RST_US * CYC_PER_US;
    localparam int POLL_CYC  = POLL_US * CYC_PER_US;
    localparam int MAX_POLLS = (TIMEOUT_US / POLL_US < 1) ? 1 : TIMEOUT_US / POLL_US;
    localparam int CNT_W     = $clog2(RST_CYC + POLL_CYC + 1);
    localparam int PW        = $clog2(MAX_POLLS + 1);
    localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(RST_CYC - 6);
    localparam logic [CNT_W-1:0] WAIT_LD = CNT_W'(POLL_CYC - 3);

    typedef struct packed {
        seq_state_t        st;
        seq_step_t         step;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              re;
        logic              we;
        logic [3:0]        idx;
        logic              div2;
        logic [PW-1:0]     polls;
        logic              done;
        logic              err;
        logic              tmo;
    } seq_regs_t;

    seq_regs_t d, q;

    logic             map_ok, map_div2;
    logic [3:0]       map_idx;
    logic             tmr_load, tmr_exp;
    logic [CNT_W-1:0] tmr_val;
    logic [DATA_W-1:0] fmask, fval;

    pbs_refmap u_map (
        .code_i (ref_code_i),
        .ok_o   (map_ok),
        .idx_o  (map_idx),
        .div2_o (map_div2)
    );

    pbs_timer #(.W(CNT_W)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .exp_o  (tmr_exp)
    );

    // Field mask and value for the step in progress
    always_comb begin
        fmask = '0;
        fval  = '0;
        case (q.step)
            K_REF: begin
                fmask = 32'h0000_000F | (q.div2 ? 32'h0000_01F0 : 32'h0);
                fval  = {28'h0, q.idx} | (q.div2 ? 32'h0000_0020 : 32'h0);
            end
            K_SRC: begin
                fmask = 32'h0000_0300;
                fval  = 32'h0;
            end
            K_LDE: begin
                fmask = 32'h0000_8000;
                fval  = 32'h0000_8000;
            end
            K_RLO: begin
                fmask = 32'h0000_0040;
                fval  = 32'h0;
            end
            default: begin
                fmask = 32'h0000_0040;
                fval  = 32'h0000_0040;
            end
        endcase
    end

    always_comb begin
        d        = q;
        d.re     = 1'b0;
        d.we     = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.done = 1'b0;
                    d.err  = 1'b0;
                    d.tmo  = 1'b0;
                    d.idx  = map_idx;
                    d.div2 = map_div2;
                    if (!map_ok) begin
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else begin
                        d.step = K_REF;
                        d.addr = A_REFCFG;
                        d.re   = 1'b1;
                        d.st   = S_RD;
                    end
                end
            end
            S_RD:  d.st = S_CAP;
            S_CAP: begin
                d.data = bus_rdata_i;
                d.st   = S_MRG;
            end
            S_MRG: begin
                d.data = (q.data & ~fmask) | (fval & fmask);
                d.we   = 1'b1;
                d.st   = S_WR;
            end
            S_WR:  d.st = S_NXT;
            S_NXT: begin
                d.re = 1'b1;
                d.st = S_RD;
                case (q.step)
                    K_REF: begin
                        d.step = q.div2 ? K_SRC : K_LDE;
                        d.addr = q.div2 ? A_SRCSEL : A_CTRL;
                    end
                    K_SRC: begin
                        d.step = K_LDE;
                        d.addr = A_CTRL;
                    end
                    K_LDE: begin
                        d.step = K_RLO;
                        d.addr = A_ANARST;
                    end
                    K_RLO: begin
                        d.re     = 1'b0;
                        d.st     = S_HOLD;
                        tmr_load = 1'b1;
                        tmr_val  = HOLD_LD;
                    end
                    default: begin
                        d.addr  = A_LOCK;
                        d.polls = PW'(1);
                        d.st    = S_PRD;
                    end
                endcase
            end
            S_HOLD: begin
                if (tmr_exp) begin
                    d.step = K_RHI;
                    d.addr = A_ANARST;
                    d.re   = 1'b1;
                    d.st   = S_RD;
                end
            end
            S_PRD: d.st = S_PCAP;
            S_PCAP: begin
                if (bus_rdata_i[LOCK_BIT]) begin
                    d.done = 1'b1;
                    d.st   = S_IDLE;
                end else if (q.polls == PW'(MAX_POLLS)) begin
                    d.done = 1'b1;
                    d.err  = 1'b1;
                    d.tmo  = 1'b1;
                    d.st   = S_IDLE;
                end else begin
                    tmr_load = 1'b1;
                    tmr_val  = WAIT_LD;
                    d.st     = S_PWAIT;
                end
            end
            S_PWAIT: begin
                if (tmr_exp) begin
                    d.re    = 1'b1;
                    d.polls = q.polls + 1'b1;
                    d.st    = S_PRD;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q.st    <= S_IDLE;
            q.step  <= K_REF;
        end else begin
            q <= d;
        end
    end

    assign bus_addr_o  = q.addr;
    assign bus_wdata_o = q.data;
    assign bus_we_o    = q.we;
    assign bus_re_o    = q.re;
    assign done_o      = q.done;
    assign err_o       = q.err;
    assign tmo_o       = q.tmo;

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_re_o && bus_we_o));

    // R9
    bus_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_re_o || bus_we_o) |=> !(bus_re_o || bus_we_o));

    // R9
    addr_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_re_o || bus_we_o) |-> (bus_addr_o[1:0] == 2'b00 && bus_addr_o <= A_MAX));

    // R9
    rmw_write_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_re_o && bus_addr_o != A_LOCK) |=> !bus_we_o ##1 !bus_we_o ##1 bus_we_o);

    // R8
    tmo_implies_err_chk: assert property (@(posedge clk) disable iff (rst)
        tmo_o |-> (err_o && done_o));

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> done_o && $stable(err_o) && $stable(tmo_o));

    // R4
    bad_code_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (q.st == S_IDLE && start_i && ref_code_i[2:1] == 2'b11)
            |=> (done_o && err_o && !bus_re_o && !bus_we_o));

endmodule

// File: tb/sim_pll_bringup_seq.sv
`timescale 1ns/1ps
module sim_pll_bringup_seq;

    localparam int CPU  = 2;
    localparam int RUS  = 10;
    localparam int PUS  = 3;
    localparam int TUS  = 24;
    localparam int RCYC = RUS * CPU;
    localparam int PCYC = PUS * CPU;
    localparam int NPOLL = TUS / PUS;

    typedef struct {
        bit          wr;
        logic [11:0] a;
        logic [31:0] d;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  ref_code = 3'd0;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we, bus_re;
    logic [31:0] bus_rdata = '0;
    logic        done, err, tmo;

    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc = 0;
    int   lock_at = 0;
    int   poll_seen = 0;
    int   lo_cyc = -1;
    int   last_poll = -1;
    bit   prev_acc = 1'b0;
    bit   finished = 1'b0;
    exp_t expq[$];
    logic [31:0] mem [0:511];

    always #2.5 clk = ~clk;

    pll_bringup_seq #(
        .CYC_PER_US (CPU),
        .RST_US     (RUS),
        .POLL_US    (PUS),
        .TIMEOUT_US (TUS)
    ) u0 (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .ref_code_i  (ref_code),
        .bus_addr_o  (bus_addr),
        .bus_wdata_o (bus_wdata),
        .bus_we_o    (bus_we),
        .bus_re_o    (bus_re),
        .bus_rdata_i (bus_rdata),
        .done_o      (done),
        .err_o       (err),
        .tmo_o       (tmo)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Register slave: read data is returned one cycle after the read strobe
    always @(posedge clk) begin
        if (start) poll_seen <= 0;
        if (bus_re) begin
            if (bus_addr == 12'h064) begin
                bus_rdata <= (poll_seen >= lock_at) ? 32'h0000_0100 : 32'hFFFF_FEFF;
                poll_seen <= poll_seen + 1;
            end else begin
                bus_rdata <= mem[bus_addr[10:2]];
            end
        end
        if (bus_we) mem[bus_addr[10:2]] <= bus_wdata;
    end

    // Monitor: pops the scoreboard as accesses appear
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (start) last_poll = -1;
            if (bus_re || bus_we) begin
                exp_t e;
                chk(!prev_acc, "R9 idle gap between accesses", 32'(cyc), 32'(cyc + 1));
                if (expq.size() == 0) begin
                    chk(1'b0, "R9 unexpected access", {20'h0, bus_addr}, 32'h0);
                end else begin
                    e = expq.pop_front();
                    chk(e.wr == bus_we && e.a == bus_addr, {e.tag, " access kind/address"},
                        {19'h0, bus_we, bus_addr}, {19'h0, e.wr, e.a});
                    if (e.wr)
                        chk(bus_wdata == e.d, {e.tag, " write data"}, bus_wdata, e.d);
                end
                if (bus_we && bus_addr == 12'h780) begin
                    if (!bus_wdata[6]) lo_cyc = cyc;
                    else chk(cyc - lo_cyc == RCYC, "R6 reset low time", 32'(cyc - lo_cyc), 32'(RCYC));
                end
                if (bus_re && bus_addr == 12'h064) begin
                    if (last_poll >= 0)
                        chk(cyc - last_poll == PCYC, "R7 poll interval", 32'(cyc - last_poll), 32'(PCYC));
                    last_poll = cyc;
                end
            end
            prev_acc = bus_re || bus_we;
        end
    end

    task automatic push(input bit wr, input logic [11:0] a, input logic [31:0] dv, input string tag);
        exp_t e;
        e.wr = wr; e.a = a; e.d = dv; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic run_seq(input logic [2:0] code, input int lk, input bit mid_start);
        bit          ok   = (code <= 3'd5);
        bit          d96  = (code == 3'd5);
        bit          pass = (lk < NPOLL);
        logic [3:0]  idx;
        logic [31:0] r, m, v, lo;
        int          np;
        string       rt = d96 ? "R3" : "R2";
        case (code)
            3'd0: idx = 4'd3;
            3'd1: idx = 4'd4;
            3'd2: idx = 4'd6;
            3'd3: idx = 4'd7;
            3'd4: idx = 4'd8;
            default: idx = 4'd7;
        endcase
        if (ok) begin
            // R11 order of accesses
            r = mem[12'h784 >> 2];
            m = d96 ? 32'h1FF : 32'h00F;
            v = {28'h0, idx} | (d96 ? 32'h20 : 32'h0);
            push(1'b0, 12'h784, '0, rt);
            push(1'b1, 12'h784, (r & ~m) | v, rt);
            if (d96) begin
                r = mem[12'h028 >> 2];
                push(1'b0, 12'h028, '0, "R3");
                push(1'b1, 12'h028, r & ~32'h300, "R3");
            end
            r = mem[12'h78C >> 2];
            push(1'b0, 12'h78C, '0, "R5");
            push(1'b1, 12'h78C, r | 32'h8000, "R5");
            lo = mem[12'h780 >> 2] & ~32'h40;
            push(1'b0, 12'h780, '0, "R6");
            push(1'b1, 12'h780, lo, "R6");
            push(1'b0, 12'h780, '0, "R6");
            push(1'b1, 12'h780, lo | 32'h40, "R6");
            np = pass ? lk + 1 : NPOLL;
            for (int i = 0; i < np; i++) push(1'b0, 12'h064, '0, pass ? "R7" : "R8");
        end
        lock_at = lk;
        @(negedge clk);
        start = 1'b1; ref_code = code;
        @(negedge clk);
        start = 1'b0; ref_code = 3'd6;
        // R10 flags cleared at the accepting edge; R4 bad code flags set there
        chk(done == !ok && err == !ok && tmo == 1'b0, "R10/R4 flags after accept",
            {29'h0, done, err, tmo}, {29'h0, !ok, !ok, 1'b0});
        if (mid_start) begin
            repeat (4) @(negedge clk);
            start = 1'b1; ref_code = 3'd7;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        if (!ok)
            chk(done && err && !tmo, "R4 unsupported code flags", {29'h0, done, err, tmo}, 32'h6);
        else if (pass)
            chk(done && !err && !tmo, mid_start ? "R10 ignored start, R7 lock" : "R7 lock flags",
                {29'h0, done, err, tmo}, 32'h4);
        else
            chk(done && err && tmo, "R8 timeout flags", {29'h0, done, err, tmo}, 32'h7);
        chk(expq.size() == 0, ok ? "R11 all expected accesses seen" : "R4 no access",
            32'(expq.size()), 32'h0);
        expq.delete();
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 32'hA5C3_3C5A ^ (32'(i) * 32'h0101_0F0F);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(!done && !err && !tmo && !bus_re && !bus_we, "R1 reset state",
            {27'h0, done, err, tmo, bus_re, bus_we}, 32'h0);
        run_seq(3'd0, 2, 1'b0);
        run_seq(3'd1, 0, 1'b0);
        run_seq(3'd2, 1, 1'b1);
        run_seq(3'd3, 2, 1'b0);
        run_seq(3'd4, 3, 1'b0);
        run_seq(3'd5, 2, 1'b0);
        run_seq(3'd6, 0, 1'b0);
        run_seq(3'd7, 0, 1'b0);
        run_seq(3'd5, 100, 1'b0);
        run_seq(3'd0, 7, 1'b0);
        repeat (20) @(negedge clk);
        // R10 flags hold while idle
        chk(done && !err && !tmo && !bus_re && !bus_we, "R10 flags held while idle",
            {27'h0, done, err, tmo, bus_re, bus_we}, 32'h10);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected 0", 1);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

endmodule